// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Engine

This block is a synthesizable model of a small serial EEPROM that sits on a three-wire bus. The bus has a select line, a serial clock and a serial data input, plus a separate serial data output with its own output enable. After select goes high, the host clocks in a start bit of 1. A 2-bit opcode follows, then an address. The engine then reads, writes or erases one word, fills or erases the whole array, or opens or closes the program-enable latch.

Reads give one zero dummy bit and then stream words most significant bit first. The address advances on its own for as long as select stays high. Every programming command starts a self-timed program cycle whose length is a parameter counted in system clocks. The host can poll that cycle through the data output: it drops select for a minimum time and raises it again. The bus pins are sampled on the system clock, and a serial clock rising edge takes effect at the first system clock edge that sees it high.

Top module: `sw3_eeprom`

## Requirements
- R1: After reset the data output enable is 0 and the program-enable latch is clear. A reset also clears a latch that was set earlier, so a write issued after the reset leaves the memory unchanged.
- R2: A command starts with the first serial-clock rising edge that samples data-in = 1 while select is high; zeros clocked in before it are skipped. The next two bits are the opcode (10 read, 01 write, 11 erase, 00 special), followed by ADDR_W address bits, most significant bit first.
- R3: On a read, the data output is enabled and shows 0 from the rising edge that samples the last address bit. Each later rising edge presents the next bit of the addressed word, most significant bit first.
- R4: While select stays high, the edge after a word's last bit presents the most significant bit of the word at the next address, with no dummy bit in between. The address wraps from the top of the array to 0.
- R5: With programming enabled, a write takes DATA_W data bits after the address and stores them at that address.
- R6: With programming enabled, erase sets every bit of the addressed word to 1, and erase-all (special code 10 in the two most significant address bits) sets every word to all ones.
- R7: With programming enabled, write-all (special code 01 in the two most significant address bits) takes DATA_W data bits and stores them in every word.
- R8: Special code 11 sets the program-enable latch and special code 00 clears it. While the latch is clear, write, erase, erase-all and write-all leave the memory unchanged.
- R9: Reads return the stored data whatever the state of the program-enable latch.
- R10: A program cycle lasts PROG_CYC system clocks from the edge that completes the command. If select was low for at least CS_MIN_LOW clocks and is raised during that cycle, the output is enabled and shows 0 while busy, then 1 once the cycle has ended, for as long as select stays high.
- R11: If select is raised only after the program cycle has ended, the data output stays disabled.
- R12: The data output enable is 0 whenever select is low.
- R13: A command whose start bit arrives during a program cycle is ignored and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Bus select, active high |
| sclk_i | input | 1 | Serial clock; rising edges shift bits |
| sdin_i | input | 1 | Serial data input |
| sdout_o | output | 1 | Serial data output (read data or ready/busy) |
| sdout_oe_o | output | 1 | Output enable for sdout_o |

## Verification
A serial-clock rising edge is acted on at the first system clock edge that sees it high. Read bits and the dummy bit therefore change at that edge, and the bench samples them on the next falling clock edge, before it lowers the serial clock. Ready/busy appears one system clock after select rises. A program cycle ends PROG_CYC clocks after the edge that took the final bit. The bench's behavioural model records that edge and predicts busy from it, and it keeps its polls and command start bits well clear of the boundary. The output enable is compared on every falling edge while select is low.

// File: rtl/sw3_pkg.sv
package sw3_pkg;

   // Opcode carried in the two bits after the start bit
   typedef enum logic [1:0] {
      OP_SPECIAL = 2'b00,
      OP_WRITE   = 2'b01,
      OP_READ    = 2'b10,
      OP_ERASE   = 2'b11
   } sw3_op_e;

   // Special command code carried in the two address MSBs
   typedef enum logic [1:0] {
      SP_DISABLE = 2'b00,
      SP_WRALL   = 2'b01,
      SP_ERALL   = 2'b10,
      SP_ENABLE  = 2'b11
   } sw3_sp_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RD,
      ST_STAT,
      ST_DONE
   } sw3_st_e;

endpackage

// File: rtl/sw3_pin_sense.sv
module sw3_pin_sense #(
   parameter int CS_MIN_LOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   output logic sclk_rise_o,
   output logic sel_rise_o,
   output logic low_ok_o
);
   localparam int LW = $clog2(CS_MIN_LOW + 1);
   localparam logic [LW-1:0] LOW_MAX = LW'(CS_MIN_LOW);

   generate
      if (CS_MIN_LOW < 1) begin : g_bad_low
         $error("sw3_pin_sense: CS_MIN_LOW must be at least 1");
      end
   endgenerate

   logic          sclk_q;
   logic          sel_q;
   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         sel_q   <= 1'b0;
         low_cnt <= '0;
      end else begin
         sclk_q <= sclk_i;
         sel_q  <= sel_i;
         if (sel_i)
            low_cnt <= '0;
         else if (low_cnt != LOW_MAX)
            low_cnt <= low_cnt + 1'b1;
      end
   end

   assign sclk_rise_o = sclk_i & ~sclk_q;
   assign sel_rise_o  = sel_i & ~sel_q;
   assign low_ok_o    = (low_cnt == LOW_MAX);

   // R10
   low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && $past(sel_i)) |-> !low_ok_o);

endmodule

// File: rtl/sw3_prog_timer.sv
module sw3_prog_timer #(
   parameter int PROG_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(PROG_CYC + 1);
   localparam logic [CW-1:0] CYC_INIT = CW'(PROG_CYC);

   generate
      if (PROG_CYC < 1) begin : g_bad_cyc
         $error("sw3_prog_timer: PROG_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (start_i)
         cnt <= CYC_INIT;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);

   // R10
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

   // R10
   countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sw3_word_store.sv
module sw3_word_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_one_i,
   input  logic              wr_all_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W > 10) begin : g_bad_depth
         $error("sw3_word_store: ADDR_W too large for a register array");
      end
   endgenerate

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (wr_all_i || (wr_one_i && (waddr_i == ADDR_W'(i))))
            words[i] <= wdata_i;
      end
   end

   assign rdata_o = words[raddr_i];

   // R8
   store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_one_i && !wr_all_i) |=> $stable(words[0]));

endmodule

// File: rtl/sw3_eeprom.sv
module sw3_eeprom
   import sw3_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 7,
   parameter int PROG_CYC   = 40,
   parameter int CS_MIN_LOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdin_i,
   output logic sdout_o,
   output logic sdout_oe_o
);
   localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int CNT_W = $clog2(MAXW + 1);
   localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
         $error("sw3_eeprom: DATA_W must be 8 or 16");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("sw3_eeprom: ADDR_W must be at least 2");
      end
   endgenerate

   logic sclk_rise, sel_rise, low_ok, busy;

   sw3_pin_sense #(.CS_MIN_LOW(CS_MIN_LOW)) u_sense (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel_i),
      .sclk_i      (sclk_i),
      .sclk_rise_o (sclk_rise),
      .sel_rise_o  (sel_rise),
      .low_ok_o    (low_ok)
   );

   sw3_st_e           st;
   sw3_op_e           opc_q;
   logic [ADDR_W-1:0] addr_sh;
   logic [DATA_W-1:0] dat_sh;
   logic [CNT_W-1:0]  bcnt;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_sh;
   logic              do_q;
   logic              en_q;

   logic              step, adr_last, dat_last;
   logic [ADDR_W-1:0] full_addr;
   logic [DATA_W-1:0] full_data;
   sw3_sp_e           sp;
   logic              wr_one, wr_all, prog_start, en_set, en_clr;
   logic [ADDR_W-1:0] waddr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rdata;

   assign step      = sel_i & ~sel_rise & sclk_rise;
   assign full_addr = {addr_sh[ADDR_W-2:0], sdin_i};
   assign full_data = {dat_sh[DATA_W-2:0], sdin_i};
   assign sp        = sw3_sp_e'(full_addr[ADDR_W-1 -: 2]);
   assign adr_last  = step && (st == ST_ADR) && (bcnt == ADR_LAST);
   assign dat_last  = step && (st == ST_DAT) && (bcnt == DAT_LAST);

   // Command decode: memory updates and latch changes
   always_comb begin
      wr_one = 1'b0;
      wr_all = 1'b0;
      waddr  = full_addr;
      wdata  = '1;
      en_set = 1'b0;
      en_clr = 1'b0;
      if (adr_last) begin
         case (opc_q)
            OP_ERASE: wr_one = en_q;
            OP_SPECIAL: begin
               case (sp)
                  SP_ENABLE:  en_set = 1'b1;
                  SP_DISABLE: en_clr = 1'b1;
                  SP_ERALL:   wr_all = en_q;
                  default:    ;
               endcase
            end
            default: ;
         endcase
      end else if (dat_last) begin
         waddr = addr_sh;
         wdata = full_data;
         if (opc_q == OP_WRITE)
            wr_one = en_q;
         else
            wr_all = en_q;
      end
   end

   assign prog_start = wr_one | wr_all;

   sw3_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (prog_start),
      .busy_o  (busy)
   );

   sw3_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_one_i (wr_one),
      .wr_all_i (wr_all),
      .waddr_i  (waddr),
      .wdata_i  (wdata),
      .raddr_i  (rd_addr),
      .rdata_o  (rdata)
   );

   // Frame sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         opc_q   <= OP_SPECIAL;
         addr_sh <= '0;
         dat_sh  <= '0;
         bcnt    <= '0;
         rd_addr <= '0;
         rd_sh   <= '0;
         do_q    <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         if (en_set)
            en_q <= 1'b1;
         else if (en_clr)
            en_q <= 1'b0;

         if (!sel_i) begin
            st <= ST_IDLE;
         end else if (sel_rise) begin
            st <= (low_ok && busy) ? ST_STAT : ST_IDLE;
         end else if (sclk_rise) begin
            case (st)
               ST_IDLE, ST_STAT: begin
                  if (sdin_i && !busy) begin
                     st   <= ST_OPC;
                     bcnt <= '0;
                  end
               end
               ST_OPC: begin
                  opc_q <= sw3_op_e'({opc_q[0], sdin_i});
                  if (bcnt == CNT_W'(1)) begin
                     st   <= ST_ADR;
                     bcnt <= '0;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               ST_ADR: begin
                  addr_sh <= full_addr;
                  if (bcnt == ADR_LAST) begin
                     bcnt <= '0;
                     case (opc_q)
                        OP_READ: begin
                           st      <= ST_RD;
                           do_q    <= 1'b0;
                           rd_addr <= full_addr;
                        end
                        OP_WRITE: st <= ST_DAT;
                        OP_SPECIAL: st <= (sp == SP_WRALL) ? ST_DAT : ST_DONE;
                        default: st <= ST_DONE;
                     endcase
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               ST_DAT: begin
                  dat_sh <= full_data;
                  if (bcnt == DAT_LAST)
                     st <= ST_DONE;
                  else
                     bcnt <= bcnt + 1'b1;
               end
               ST_RD: begin
                  if (bcnt == '0) begin
                     do_q  <= rdata[DATA_W-1];
                     rd_sh <= {rdata[DATA_W-2:0], 1'b0};
                     bcnt  <= DAT_LAST;
                  end else begin
                     do_q  <= rd_sh[DATA_W-1];
                     rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                     bcnt  <= bcnt - 1'b1;
                     if (bcnt == CNT_W'(1))
                        rd_addr <= rd_addr + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sdout_oe_o = sel_i && ((st == ST_RD) || (st == ST_STAT));
   assign sdout_o    = (st == ST_STAT) ? ~busy : do_q;

   // R3
   dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_RD) && ($past(st) != ST_RD)) |-> !do_q);

   // R13
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !prog_start);

   // R8
   latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> en_q);

   // R10
   status_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_STAT) && ($past(st) != ST_STAT)) |-> $past(busy));

endmodule

// File: tb/sw3_eeprom_tb.sv
module sw3_eeprom_tb;
   localparam int DW = 16;
   localparam int AW = 7;
   localparam int PC = 120;
   localparam int CL = 4;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0;
   logic sclk = 1'b0;
   logic sdin = 1'b0;
   logic sdout, sdout_oe;

   sw3_eeprom #(.DATA_W(DW), .ADDR_W(AW), .PROG_CYC(PC), .CS_MIN_LOW(CL)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel),
      .sclk_i     (sclk),
      .sdin_i     (sdin),
      .sdout_o    (sdout),
      .sdout_oe_o (sdout_oe)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc++;

   int errs = 0;
   int checks = 0;
   bit finished = 1'b0;

   // Behavioural reference model
   logic [DW-1:0] model_mem [DEPTH];
   bit model_en = 1'b0;
   int t0 = -100000;

   logic last_do, last_oe;
   int last_q;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit busy_at(input int q);
      return (q > t0) && (q <= t0 + PC);
   endfunction

   // R12: enable compared on every clock while select is low
   always @(negedge clk) begin
      if (rst_n && !sel && !finished)
         chk(sdout_oe == 1'b0, "R12 output enabled while select low", sdout_oe, 0);
   end

   task automatic sk_bit(input logic b);
      sdin = b;
      sclk = 1'b1;
      @(negedge clk);
      last_do = sdout;
      last_oe = sdout_oe;
      last_q  = cyc;
      sclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic hdr(input logic [1:0] opc, input logic [AW-1:0] a, input int nz, output bit started);
      sel = 1'b0;
      repeat (CL + 2) @(negedge clk);
      sel = 1'b1;
      @(negedge clk);
      for (int i = 0; i < nz; i++) sk_bit(1'b0);
      sk_bit(1'b1);
      started = !busy_at(last_q);
      sk_bit(opc[1]);
      sk_bit(opc[0]);
      for (int i = AW - 1; i >= 0; i--) sk_bit(a[i]);
   endtask

   task automatic cmd_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit s;
      hdr(2'b01, a, 0, s);
      for (int i = DW - 1; i >= 0; i--) sk_bit(d[i]);
      if (s && model_en) begin
         model_mem[a] = d;
         t0 = last_q;
      end
   endtask

   task automatic cmd_erase(input logic [AW-1:0] a);
      bit s;
      hdr(2'b11, a, 0, s);
      if (s && model_en) begin
         model_mem[a] = '1;
         t0 = last_q;
      end
   endtask

   task automatic cmd_special(input logic [1:0] code);
      bit s;
      hdr(2'b00, {code, {(AW-2){1'b0}}}, 0, s);
      if (s) begin
         if (code == 2'b11) model_en = 1'b1;
         if (code == 2'b00) model_en = 1'b0;
         if (code == 2'b10 && model_en) begin
            for (int i = 0; i < DEPTH; i++) model_mem[i] = '1;
            t0 = last_q;
         end
      end
   endtask

   task automatic cmd_wral(input logic [DW-1:0] d);
      bit s;
      hdr(2'b00, {2'b01, {(AW-2){1'b0}}}, 0, s);
      for (int i = DW - 1; i >= 0; i--) sk_bit(d[i]);
      if (s && model_en) begin
         for (int i = 0; i < DEPTH; i++) model_mem[i] = d;
         t0 = last_q;
      end
   endtask

   task automatic read_words(input logic [AW-1:0] a, input int n, input int nz, input string tag);
      bit s;
      logic [DW-1:0] got;
      logic [DW-1:0] exp;
      hdr(2'b10, a, nz, s);
      chk(last_oe == 1'b1 && last_do == 1'b0, "R3 dummy bit after address", {last_oe, last_do}, 2'b10);
      for (int w = 0; w < n; w++) begin
         exp = model_mem[(int'(a) + w) % DEPTH];
         got = '0;
         for (int b = 0; b < DW; b++) begin
            sk_bit(1'b0);
            got = {got[DW-2:0], last_do};
         end
         chk(got == exp, tag, got, exp);
      end
   endtask

   task automatic wait_done();
      sel = 1'b0;
      repeat (PC + 10) @(negedge clk);
   endtask

   // R10: poll during the cycle, then hold select until it ends
   task automatic poll_status();
      sel = 1'b0;
      repeat (CL + 2) @(negedge clk);
      sel = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(sdout_oe == 1'b1 && sdout == 1'b0, "R10 busy shown as 0", {sdout_oe, sdout}, 2'b10);
      repeat (PC + 5) @(negedge clk);
      chk(sdout_oe == 1'b1 && sdout == 1'b1, "R10 ready shown as 1", {sdout_oe, sdout}, 2'b11);
      sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic print_summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      #(20 * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      print_summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sdout_oe == 1'b0, "R1 output disabled after reset", sdout_oe, 0);

      // R8 enable, R6 erase-all with R10 status poll
      cmd_special(2'b11);
      cmd_special(2'b10);
      poll_status();
      read_words(7'd0, 3, 0, "R6 erase-all gives all ones");

      // R5 write, R4 sequential read
      cmd_write(7'd3, 16'hA5C3);
      wait_done();
      read_words(7'd3, 2, 0, "R5 R4 written word then next");
      cmd_write(7'd127, 16'h1357);
      wait_done();
      read_words(7'd127, 2, 0, "R4 wrap from top address");

      // R6 single erase
      cmd_erase(7'd3);
      wait_done();
      read_words(7'd3, 1, 0, "R6 erased word");

      // R13 command during a program cycle
      cmd_write(7'd10, 16'h1111);
      cmd_write(7'd11, 16'h2222);
      wait_done();
      read_words(7'd10, 2, 0, "R13 busy-time write ignored");

      // R11 select raised after the cycle ended
      cmd_write(7'd12, 16'h0F00);
      wait_done();
      sel = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(sdout_oe == 1'b0, "R11 no status after cycle", sdout_oe, 0);
      read_words(7'd12, 1, 0, "R5 word after late select");

      // R7 write-all
      cmd_wral(16'h0F0F);
      wait_done();
      read_words(7'd0, 1, 0, "R7 write-all word 0");
      read_words(7'd100, 1, 0, "R7 write-all word 100");

      // R8 disable, R9 read while disabled
      cmd_special(2'b00);
      cmd_write(7'd0, 16'h0000);
      cmd_erase(7'd1);
      cmd_special(2'b10);
      wait_done();
      read_words(7'd0, 2, 0, "R8 R9 disabled programs ignored");

      // R1 reset clears a set latch
      cmd_special(2'b11);
      sel = 1'b0;
      rst_n = 1'b0;
      model_en = 1'b0;
      t0 = -100000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sdout_oe == 1'b0, "R1 output disabled after second reset", sdout_oe, 0);
      cmd_write(7'd1, 16'h0000);
      wait_done();
      read_words(7'd1, 1, 0, "R1 latch cleared by reset");

      // R2 leading zeros before the start bit
      read_words(7'd5, 1, 3, "R2 leading zeros skipped");

      sel = 1'b0;
      repeat (4) @(negedge clk);
      finished = 1'b1;
      print_summary();
      $finish;
   end

endmodule